// File: doc/BRIEF.md
# Dual-Convention Host Register Port

This block is a slave port through which an external processor reads and writes a bank of sixteen 8-bit registers. It understands two host bus conventions. In the direction-line convention, one line gives read or write and a data strobe gives the timing. In the split-strobe convention, there is one read strobe and one write strobe, and the address comes either from a dedicated address bus or from the data lines through an address-latch strobe. A strap input chooses the convention. The block samples the strap while reset is held, and the last value before reset is released stays in force until the next reset.

Every host input passes through a two-stage synchroniser into the internal clock domain. Strobe edges are detected in that domain. A write captures address and data while its strobe is active and commits them to the register bank on the clock after the strobe's trailing edge is seen. A read registers the addressed value and raises an output-enable so that an external pad can drive the data bus. Addresses at sixteen and above read as zero and cannot be written.

Top module: `hostbus_slave`

## Requirements
- R1: With the strap high (1), the direction-line convention is active: `bus_rw` = 1 means read, 0 means write, and `bus_ds_n` times the access. `bus_rd_n` and `bus_wr_n` have no effect. With the strap low (0), the split-strobe convention is active: `bus_rd_n` times reads, `bus_wr_n` times writes, and `bus_ds_n` and `bus_rw` have no effect.
- R2: The convention is the strap value held while `rst_n` is low. Changing the strap after reset is released has no effect until the next reset.
- R3: In the direction-line convention the address always comes from `bus_addr`. Pulses on `bus_ale` (active high) are ignored.
- R4: In the split-strobe convention the address comes from `bus_addr` until the first `bus_ale` pulse after reset. From then until the next reset, the address is the value on `bus_din[ADDR_W-1:0]` at the falling edge of the most recent `bus_ale` pulse. A new pulse replaces it.
- R5: In the direction-line convention a write takes effect only when `bus_rw` is 0 throughout the active strobe. During a write, `bus_doe` stays low.
- R6: An access strobe counts only while `bus_cs_n` is also low. With `bus_cs_n` high, strobes neither write a register nor raise `bus_doe`.
- R7: A write stores the address and data that were present while the strobe was active. The value is committed one internal clock after the strobe's trailing edge is detected. A following read returns the written value.
- R8: `bus_doe` rises on the third clock edge after the read strobe goes active at the pins. It falls on the third clock edge after the strobe is released. While it is high, `bus_dout` holds the addressed register.
- R9: A register index of 16 or more reads as 0x00. Writes to such an index change no register.
- R10: After reset all registers read 0x00, and `bus_doe` and `bus_dout` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is sampled while it is low |
| strap_mode | input | 1 | Convention strap: 1 = direction-line, 0 = split-strobe |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_ds_n | input | 1 | Data strobe for the direction-line convention, active low |
| bus_rw | input | 1 | Direction for the direction-line convention: 1 = read, 0 = write |
| bus_rd_n | input | 1 | Read strobe for the split-strobe convention, active low |
| bus_wr_n | input | 1 | Write strobe for the split-strobe convention, active low |
| bus_ale | input | 1 | Address-latch strobe for the split-strobe convention, active high |
| bus_addr | input | ADDR_W | Dedicated address bus |
| bus_din | input | DATA_W | Data lines in; in multiplexed use they also carry the address |
| bus_dout | output | DATA_W | Read data for the external pad |
| bus_doe | output | 1 | Output enable for the external data pad |

## Verification
Assertions check every cycle that the latched convention never changes outside reset, and that a pulse on the address-latch strobe never switches the direction-line convention into multiplexed addressing. They also check every cycle that the latched address holds between pulses, that the output enable stays low without chip select or during a write, that every commit follows an active strobe, and that an out-of-range index reads as zero and leaves the bank untouched. Other behaviours show only through the bench's scenarios. These are: the exact clock on which the output enable rises and falls relative to the pins, the fact that ignored strobe lines do not write in each convention, strap changes after reset, the switch from dedicated to multiplexed addressing, and random write/read traffic compared against a reference model.

// File: rtl/hbs_pkg.sv
// Shared types for the host register port.
// Assumes nothing beyond a single internal clock domain.
package hbs_pkg;

    // Bus convention chosen by the reset-time strap.
    typedef enum logic {
        CONV_SPLIT = 1'b0,
        CONV_RWDS  = 1'b1
    } conv_e;

    // Control lines of the host bus as one bundle.
    typedef struct packed {
        logic cs_n;
        logic ds_n;
        logic rw;
        logic rd_n;
        logic wr_n;
        logic ale;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Idle levels of the control lines, used as synchroniser reset values.
    localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, ds_n: 1'b1, rw: 1'b1,
                                  rd_n: 1'b1, wr_n: 1'b1, ale: 1'b0};

endpackage

// File: rtl/hbs_sync.sv
// Two-flop synchroniser for a vector of asynchronous host inputs.
// Each bit is synchronised on its own. Multi-bit coherence is the host's
// job: address and data must be stable around the strobe edges.
module hbs_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;

        // Two register stages per bit, reset to the idle level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta      <= RST_VAL[i];
                q_sync[i] <= RST_VAL[i];
            end else begin
                meta      <= d_async[i];
                q_sync[i] <= meta;
            end
        end
    end

endmodule

// File: rtl/hbs_decode.sv
// Access decoder: latches the convention strap during reset, combines the
// strobes with chip select, detects the trailing edge of a write, takes a
// snapshot of address and data, and picks between the dedicated and the
// multiplexed address.
// Assumes synchronised inputs and ADDR_W <= DATA_W (the multiplexed address
// travels on the low data lines).
module hbs_decode
    import hbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_data,
    output conv_e             conv,
    output logic              acc_active,
    output logic              acc_read,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mux_mode
);

    conv_e             mode_q;
    logic              rwds_on, rd_on, wr_on;
    logic              write_low, write_low_q, wr_edge;
    logic              ale_q, ale_fall;
    logic [ADDR_W-1:0] lat_addr;
    logic [ADDR_W-1:0] snap_addr;
    logic [DATA_W-1:0] snap_data;
    logic              fire_q;

    assign conv = mode_q;

    // Strap capture: follows the pin during reset and freezes at release.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= conv_e'(strap);
    end

    // Combined strobes: active only with chip select low.
    always_comb begin
        rwds_on = !ctl.ds_n && !ctl.cs_n;
        rd_on   = !ctl.rd_n && !ctl.cs_n;
        wr_on   = !ctl.wr_n && !ctl.cs_n;
    end

    // Access qualification for the latched convention.
    always_comb begin
        if (mode_q == CONV_RWDS) begin
            acc_active = rwds_on;
            acc_read   = rwds_on && ctl.rw;
            write_low  = rwds_on && !ctl.rw;
        end else begin
            acc_active = rd_on || wr_on;
            acc_read   = rd_on;
            write_low  = wr_on;
        end
    end

    assign wr_edge  = write_low_q && !write_low;
    assign ale_fall = ale_q && !ctl.ale;

    // Edge history for the write strobe and the address-latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_low_q <= 1'b0;
            ale_q       <= 1'b0;
        end else begin
            write_low_q <= write_low;
            ale_q       <= ctl.ale;
        end
    end

    // Multiplexed address: tracks the data lines while the latch strobe is
    // high, so it holds the value present at the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            mux_mode <= 1'b0;
        end else if (mode_q == CONV_SPLIT) begin
            if (ctl.ale) lat_addr <= s_data[ADDR_W-1:0];
            if (ale_fall) mux_mode <= 1'b1;
        end
    end

    assign cur_addr = mux_mode ? lat_addr : s_addr;

    // Write snapshot: address and data as seen while the write strobe is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_addr <= '0;
            snap_data <= '0;
        end else if (write_low) begin
            snap_addr <= cur_addr;
            snap_data <= s_data;
        end
    end

    // Commit strobe: one clock after the trailing edge is detected.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= wr_edge;
    end

    assign wr_fire = fire_q;
    assign wr_addr = snap_addr;
    assign wr_data = snap_data;

    // R2: the convention stays frozen while out of reset.
    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));

    // R3: the direction-line convention never enters multiplexed addressing.
    assert_ale_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CONV_RWDS) |-> !mux_mode);

    // R4: the latched address holds while the latch strobe stays low.
    assert_lat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctl.ale) |-> $stable(lat_addr));

endmodule

// File: rtl/hbs_regfile.sv
// Bank of NREG registers with one write port and one combinational read port.
// Indices at NREG or above read as zero, and writes to them are dropped.
// Assumes NREG is a power of two no larger than 2**ADDR_W.
module hbs_regfile #(
    parameter int NREG   = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rhit
);

    localparam int              IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W:0] LIMIT  = (ADDR_W + 1)'(NREG);

    logic [NREG-1:0][DATA_W-1:0] rf;
    logic                        whit;

    assign whit = ({1'b0, waddr} < LIMIT);
    assign rhit = ({1'b0, raddr} < LIMIT);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Register i: cleared by reset, loaded by an in-range write to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rf[i] <= '0;
            else if (we && whit && (waddr[IDX_W-1:0] == IDX_W'(i)))
                rf[i] <= wdata;
        end
    end

    // Read mux with zero for out-of-range indices.
    always_comb begin
        rdata = '0;
        if (rhit) rdata = rf[raddr[IDX_W-1:0]];
    end

    // R7: an in-range write lands in the addressed register.
    assert_commit_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && whit) |=> (rf[$past(waddr[IDX_W-1:0])] == $past(wdata)));

    // R9: an out-of-range write leaves the whole bank unchanged.
    assert_oob_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !whit) |=> $stable(rf));

endmodule

// File: rtl/hostbus_slave.sv
// Top of the host register port: synchronises the host pins, decodes
// accesses in the strap-selected convention, and holds the register bank
// and the registered read stage.
// Assumes the host keeps address, direction and data stable for at least
// three internal clocks around each strobe edge.
module hostbus_slave
    import hbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NREG   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_mode,
    input  logic              bus_cs_n,
    input  logic              bus_ds_n,
    input  logic              bus_rw,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              bus_ale,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe
);

    ctl_t              ctl_raw, ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    conv_e             conv;
    logic              acc_active, acc_read, wr_fire, mux_mode;
    logic [ADDR_W-1:0] wr_addr, cur_addr;
    logic [DATA_W-1:0] wr_data, rdata;
    logic              rhit;
    logic [DATA_W-1:0] dout_q;
    logic              doe_q;

    assign ctl_raw = '{cs_n: bus_cs_n, ds_n: bus_ds_n, rw: bus_rw,
                       rd_n: bus_rd_n, wr_n: bus_wr_n, ale: bus_ale};

    hbs_sync #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d_async(ctl_raw), .q_sync(ctl_s)
    );

    hbs_sync #(.W(ADDR_W), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d_async(bus_addr), .q_sync(addr_s)
    );

    hbs_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d_async(bus_din), .q_sync(data_s)
    );

    hbs_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .strap(strap_mode), .ctl(ctl_s),
        .s_addr(addr_s), .s_data(data_s), .conv(conv),
        .acc_active(acc_active), .acc_read(acc_read), .wr_fire(wr_fire),
        .wr_addr(wr_addr), .wr_data(wr_data), .cur_addr(cur_addr),
        .mux_mode(mux_mode)
    );

    hbs_regfile #(.NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regfile (
        .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(wr_addr),
        .wdata(wr_data), .raddr(cur_addr), .rdata(rdata), .rhit(rhit)
    );

    // Registered read stage: data follows the addressed register, enable
    // follows the qualified read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            doe_q  <= 1'b0;
        end else begin
            dout_q <= rdata;
            doe_q  <= acc_read;
        end
    end

    assign bus_dout = dout_q;
    assign bus_doe  = doe_q;

    // R6: with chip select high the pad is released on the next clock.
    assert_doe_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_s.cs_n |=> !doe_q);

    // R5: a write direction in the direction-line convention never drives the pad.
    assert_no_doe_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv == CONV_RWDS && !ctl_s.rw) |=> !doe_q);

    // R7: every commit is preceded by an active strobe two clocks earlier.
    assert_commit_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> $past(acc_active, 2));

    // R9: an out-of-range index reads back as zero.
    assert_oob_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rhit) |-> (dout_q == '0));

    // R4: multiplexed addressing only in the split-strobe convention.
    assert_mux_only_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mux_mode |-> (conv == CONV_SPLIT));

endmodule

// File: tb/hostbus_slave_tb.sv
module hostbus_slave_tb;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NR = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_mode = 1'b1;
    logic          bus_cs_n = 1'b1, bus_ds_n = 1'b1, bus_rw = 1'b1;
    logic          bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_ale = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_din = '0;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [NR];

    always #4 clk = ~clk;

    hostbus_slave #(.ADDR_W(AW), .DATA_W(DW), .NREG(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode),
        .bus_cs_n(bus_cs_n), .bus_ds_n(bus_ds_n), .bus_rw(bus_rw),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ale(bus_ale),
        .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe)
    );

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        return (a < NR) ? model[a[3:0]] : '0;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; strap_mode = strap;
        bus_cs_n = 1'b1; bus_ds_n = 1'b1; bus_rw = 1'b1;
        bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_ale = 1'b0;
        waitn(3);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) model[i] = '0;
        waitn(2);
    endtask

    // Direction-line write; cs selects whether chip select is asserted.
    task automatic rw_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic cs);
        @(negedge clk);
        bus_addr = a; bus_din = d; bus_rw = 1'b0; bus_ds_n = 1'b0; bus_cs_n = !cs;
        waitn(4);
        bus_ds_n = 1'b1; bus_cs_n = 1'b1;
        waitn(4);
        bus_rw = 1'b1;
        if (cs && a < NR) model[a[3:0]] = d;
    endtask

    // Split-strobe write, with optional multiplexed address phase.
    task automatic sp_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic mux);
        @(negedge clk);
        if (mux) begin
            bus_addr = ~a; bus_din = a; bus_ale = 1'b1;
            waitn(3); bus_ale = 1'b0; waitn(3);
        end else bus_addr = a;
        bus_din = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        waitn(4);
        bus_wr_n = 1'b1; bus_cs_n = 1'b1;
        waitn(4);
        if (a < NR) model[a[3:0]] = d;
    endtask

    // Read in either convention with enable timing checks (R8).
    task automatic do_read(input logic rwds, input logic [AW-1:0] a, input logic mux, input string req);
        @(negedge clk);
        if (mux) begin
            bus_addr = ~a; bus_din = a; bus_ale = 1'b1;
            waitn(3); bus_ale = 1'b0; waitn(3);
        end else bus_addr = a;
        bus_cs_n = 1'b0;
        if (rwds) begin bus_rw = 1'b1; bus_ds_n = 1'b0; end
        else bus_rd_n = 1'b0;
        waitn(2);
        chk("R8 doe still low 2 clk after strobe", bus_doe, 1'b0);
        waitn(1);
        chk("R8 doe high 3 clk after strobe", bus_doe, 1'b1);
        waitn(2);
        chk(req, bus_dout, exp_read(a));
        bus_ds_n = 1'b1; bus_rd_n = 1'b1; bus_cs_n = 1'b1;
        waitn(2);
        chk("R8 doe still high 2 clk after release", bus_doe, 1'b1);
        waitn(1);
        chk("R8 doe low 3 clk after release", bus_doe, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        void'($urandom(32'd2024));

        // R10: reset state.
        do_reset(1'b1);
        chk("R10 doe after reset", bus_doe, 1'b0);
        chk("R10 dout after reset", bus_dout, 8'h00);
        do_read(1'b1, 8'd3, 1'b0, "R10 register zero after reset");

        // R2: strap changed after release is ignored.
        strap_mode = 1'b0;
        rw_write(8'd5, 8'hA5, 1'b1);
        do_read(1'b1, 8'd5, 1'b0, "R2 direction-line still active");

        // R9 directed: top index, boundary and far out of range.
        rw_write(8'd15, 8'h3C, 1'b1);
        do_read(1'b1, 8'd15, 1'b0, "R9 last register in range");
        rw_write(8'd16, 8'h77, 1'b1);
        do_read(1'b1, 8'd16, 1'b0, "R9 index 16 reads zero");
        do_read(1'b1, 8'd0, 1'b0, "R9 alias index 0 untouched");

        // R6: strobe without chip select neither writes nor enables.
        rw_write(8'd5, 8'h11, 1'b0);
        do_read(1'b1, 8'd5, 1'b0, "R6 write without cs ignored");
        @(negedge clk);
        bus_addr = 8'd5; bus_rw = 1'b1; bus_ds_n = 1'b0;
        waitn(5);
        chk("R6 doe without cs", bus_doe, 1'b0);
        bus_ds_n = 1'b1;

        // R5: write direction never enables the pad.
        @(negedge clk);
        bus_addr = 8'd6; bus_din = 8'h66; bus_rw = 1'b0; bus_cs_n = 1'b0; bus_ds_n = 1'b0;
        waitn(5);
        chk("R5 doe low during write", bus_doe, 1'b0);
        bus_ds_n = 1'b1; bus_cs_n = 1'b1; waitn(4); bus_rw = 1'b1;
        model[6] = 8'h66;
        do_read(1'b1, 8'd6, 1'b0, "R5 write committed");

        // R1: split write strobe ignored in direction-line convention.
        @(negedge clk);
        bus_addr = 8'd6; bus_din = 8'h99; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        waitn(4); bus_wr_n = 1'b1; bus_cs_n = 1'b1; waitn(4);
        do_read(1'b1, 8'd6, 1'b0, "R1 split strobe ignored");

        // R3: latch strobe pulse does not redirect the address.
        @(negedge clk);
        bus_din = 8'd9; bus_ale = 1'b1; waitn(3); bus_ale = 1'b0; waitn(3);
        rw_write(8'd2, 8'h5A, 1'b1);
        do_read(1'b1, 8'd2, 1'b0, "R3 address bus used");
        do_read(1'b1, 8'd9, 1'b0, "R3 latched address not used");

        // R7: random traffic in the direction-line convention.
        for (int i = 0; i < 20; i++) begin
            a = AW'($urandom_range(0, 20)); d = DW'($urandom);
            rw_write(a, d, 1'b1);
        end
        for (int i = 0; i < 12; i++) begin
            a = AW'($urandom_range(0, 20));
            do_read(1'b1, a, 1'b0, "R7 random direction-line read");
        end

        // Split-strobe convention.
        do_reset(1'b0);
        do_read(1'b0, 8'd5, 1'b0, "R10 bank cleared by reset");
        @(negedge clk);
        bus_addr = 8'd4; bus_din = 8'h44; bus_rw = 1'b0; bus_cs_n = 1'b0; bus_ds_n = 1'b0;
        waitn(4); bus_ds_n = 1'b1; bus_cs_n = 1'b1; waitn(4); bus_rw = 1'b1;
        do_read(1'b0, 8'd4, 1'b0, "R1 data strobe ignored in split");

        // R4: dedicated address bus before any latch pulse.
        for (int i = 0; i < 10; i++) begin
            a = AW'($urandom_range(0, 18)); d = DW'($urandom);
            sp_write(a, d, 1'b0);
            do_read(1'b0, a, 1'b0, "R4 demultiplexed read");
        end

        // R4 / R9: multiplexed address after latch pulses.
        for (int i = 0; i < 14; i++) begin
            a = AW'($urandom_range(0, 18)); d = DW'($urandom);
            sp_write(a, d, 1'b1);
            do_read(1'b0, a, 1'b1, "R4 multiplexed read");
        end
        sp_write(8'd200, 8'hEE, 1'b1);
        do_read(1'b0, 8'd200, 1'b1, "R9 multiplexed out of range");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule